// File: doc/BRIEF.md
# Byte-Lane Static Memory Model with Dual Chip Enables

This block stands in for an asynchronous 16-bit static memory inside a clocked design. Every control pin is first brought into the system clock domain. The pins are an active-low chip enable, an active-high chip enable, an active-low write strobe, an active-low output enable and one active-low enable for each byte lane. Each clock cycle, the synchronised pins are decoded into one of five modes:

- standby
- selected with no lane enabled
- write
- read
- selected with the output turned off

Storage is kept in one array per byte lane, so a synthesis tool can map it onto block RAM. The data bus is shown as a value plus one drive-enable bit per lane, which is how a tri-state pad is modelled inside a chip. A write collects its address, data and lane mask while the strobe is low. It commits them once, when the write ends. The block also raises a flag when a read stays inside the same page as the read in the previous cycle, so that power can be accounted for.

Top module: `sram_emu`

## Requirements
- R1: If `ce1_n` is high or `ce2` is low, both bits of `dout_oe` are 0.
- R2: While deselected, activity on `we_n`, `oe_n`, `lb_n`, `ub_n`, `addr` and `din` leaves the stored contents unchanged.
- R3: When selected with `lb_n` and `ub_n` both high, `dout_oe` is 0 and a strobe on `we_n` writes nothing.
- R4: When selected with `we_n` low, the access is a write whatever `oe_n` is, and `dout_oe` is 0.
- R5: Reading requires selection, `we_n` high and `oe_n` low. With `oe_n` high, `dout_oe` stays 0 even though the device is selected.
- R6: `lb_n` controls bits 7:0 and `dout_oe[0]`; `ub_n` controls bits 15:8 and `dout_oe[1]`. Either lane can be read or written alone, or both together. A lane that is not driven shows 0 on `dout`.
- R7: A write stores the address, data and lanes that were present in the last cycle of the write. It commits when `we_n` rises or when the device is deselected, whichever comes first. A read in the cycle of the commit already returns the new data.
- R8: `page_open` is 1 for a read cycle whose page (address bits above the low `WORD_BITS`) equals the page of a read in the cycle just before it.
- R9: Synchronous reset clears `dout_oe` and `page_open` and leaves the stored contents intact.
- R10: Outputs respond to a pin change after `SYNC_STAGES + 1` rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, 0 on lanes not driven |
| dout_oe | output | 2 | Per-lane bus drive enable (bit 0 lower, bit 1 upper) |
| page_open | output | 1 | Read stayed in the previous read's page |

## Verification
The bench builds the block with `ADDR_W = 6` and `WORD_BITS = 2`. That gives 64 words in 16 pages, so every address can be written and read back under every lane mask against a model computed in the bench. The small depth also lets the bench cover the following cases completely:

- deselect-ended writes
- writes that ignore the output enable
- reads in the same cycle as a commit
- page crossings
- resets in the middle of a read

With the default two synchroniser stages, the latency can be pinned to an exact edge.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_NOLANE,
    MODE_WRITE,
    MODE_READ,
    MODE_OUTOFF
  } mode_e;

  // Priority: deselect, then no lane, then write (oe ignored), then read.
  function automatic mode_e decode_mode(input logic ce1_n, input logic ce2,
                                        input logic we_n, input logic oe_n,
                                        input logic any_lane);
    if (ce1_n || !ce2)  return MODE_STANDBY;
    else if (!any_lane) return MODE_NOLANE;
    else if (!we_n)     return MODE_WRITE;
    else if (!oe_n)     return MODE_READ;
    else                return MODE_OUTOFF;
  endfunction
endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              sel,
  output logic              is_wr,
  output logic              is_rd,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_mask,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  dout_oe,
  output logic              page_open
);
  localparam int PAGE_W = ADDR_W - WORD_BITS;

  mode_e             mode;
  logic [LANES-1:0]  lane_en;
  logic              pend_v;
  logic              last_rd;
  logic [PAGE_W-1:0] last_page;
  logic [PAGE_W-1:0] page;

  assign lane_en = ~lane_n;
  assign mode    = decode_mode(ce1_n, ce2, we_n, oe_n, |lane_en);
  assign sel     = (mode != MODE_STANDBY);
  assign is_wr   = (mode == MODE_WRITE);
  assign is_rd   = (mode == MODE_READ);
  assign page    = addr[ADDR_W-1:WORD_BITS];

  // A pending write commits in the first cycle that is not a write cycle.
  assign wr_en = pend_v && !is_wr;

  always_ff @(posedge clk) begin
    if (is_wr) begin
      wr_addr <= addr;
      wr_data <= din;
      wr_mask <= lane_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      dout_oe   <= '0;
      page_open <= 1'b0;
      last_rd   <= 1'b0;
      last_page <= '0;
    end else begin
      if (is_wr)       pend_v <= 1'b1;
      else if (pend_v) pend_v <= 1'b0;
      dout_oe   <= is_rd ? lane_en : '0;
      page_open <= is_rd && last_rd && (page == last_page);
      last_rd   <= is_rd;
      last_page <= page;
    end
  end
endmodule

// File: rtl/sram_emu_lanes.sv
module sram_emu_lanes #(
  parameter int ADDR_W = 10,
  parameter int LANES = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] byp_q;
    logic              byp_v;
    logic              lane_we;

    assign lane_we = wr_en && wr_mask[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      rd_q <= mem[rd_addr];
    end

    // Forward a same-cycle commit so the read never sees stale data.
    always_ff @(posedge clk) begin
      byp_v <= lane_we && (wr_addr == rd_addr);
      byp_q <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = byp_v ? byp_q : rd_q;
  end
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_BITS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        dout_oe,
  output logic              page_open
);
  localparam int SW = 6 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {6'b101111, {(ADDR_W + DATA_W){1'b0}}};

  logic [SW-1:0]     sync_q;
  logic              s_ce1_n, s_ce2, s_we_n, s_oe_n, s_lb_n, s_ub_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              s_sel, s_wr, s_rd, s_commit;
  logic [LANES-1:0]  s_lane_en;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  sram_emu_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce1_n, ce2, we_n, oe_n, lb_n, ub_n, addr, din}),
    .q   (sync_q)
  );

  assign {s_ce1_n, s_ce2, s_we_n, s_oe_n, s_lb_n, s_ub_n, s_addr, s_din} = sync_q;
  assign s_lane_en = ~{s_ub_n, s_lb_n};

  sram_emu_ctrl #(.ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ce1_n     (s_ce1_n),
    .ce2       (s_ce2),
    .we_n      (s_we_n),
    .oe_n      (s_oe_n),
    .lane_n    ({s_ub_n, s_lb_n}),
    .addr      (s_addr),
    .din       (s_din),
    .sel       (s_sel),
    .is_wr     (s_wr),
    .is_rd     (s_rd),
    .wr_en     (s_commit),
    .wr_mask   (wr_mask),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dout_oe   (dout_oe),
    .page_open (page_open)
  );

  sram_emu_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk     (clk),
    .wr_en   (s_commit),
    .wr_mask (wr_mask),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (s_addr),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dout[g*LANE_W +: LANE_W] = dout_oe[g] ? rd_data[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel,
  input logic       is_wr,
  input logic       is_rd,
  input logic       commit,
  input logic [1:0] lane_en,
  input logic [1:0] dout_oe,
  input logic       page_open
);
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (dout_oe == 2'b00));

  assert_nolane_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && lane_en == 2'b00) |=> (dout_oe == 2'b00));

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> (dout_oe == 2'b00));

  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> (dout_oe == $past(lane_en)));

  assert_only_read_drives_R5: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> (dout_oe == 2'b00));

  // R2/R7: a commit only ever follows a write cycle.
  assert_commit_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(is_wr));

  assert_page_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
    page_open |-> (dout_oe != 2'b00));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (dout_oe == 2'b00 && !page_open));
endmodule

bind sram_emu sram_emu_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (s_sel),
  .is_wr     (s_wr),
  .is_rd     (s_rd),
  .commit    (s_commit),
  .lane_en   (s_lane_en),
  .dout_oe   (dout_oe),
  .page_open (page_open)
);

// File: tb/sram_emu_bench.sv
module sram_emu_bench;
  localparam int AW = 6;
  localparam int WB = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_oe;
  logic        page_open;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  sram_emu #(.ADDR_W(AW), .WORD_BITS(WB), .SYNC_STAGES(2)) u_sram_emu (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .page_open(page_open)
  );

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h0123) ^ (k * 16'h4567) ^ 16'hA5C3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c1n, input logic c2, input logic wn, input logic on,
                       input logic lbn, input logic ubn, input int a, input logic [15:0] d);
    @(negedge clk);
    ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on; lb_n = lbn; ub_n = ubn;
    addr = AW'(a); din = d;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input logic lbn, input logic ubn);
    drive(1'b0, 1'b1, 1'b0, 1'b1, lbn, ubn, a, d);
    settle();
    drive(1'b0, 1'b1, 1'b1, 1'b1, lbn, ubn, a, d);
    settle();
    if (!lbn) model[a][7:0]  = d[7:0];
    if (!ubn) model[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input string req, input int a, input logic lbn, input logic ubn);
    logic [15:0] msk;
    msk = {{8{~ubn}}, {8{~lbn}}};
    drive(1'b0, 1'b1, 1'b1, 1'b0, lbn, ubn, a, 16'h0);
    settle();
    check(req, {30'd0, dout_oe}, {30'd0, ~ubn, ~lbn});
    check(req, {16'd0, dout}, {16'd0, model[a] & msk});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset oe", {30'd0, dout_oe}, 32'd0);
    check("R9 reset page", {31'd0, page_open}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R5: full sweep, both lanes
    for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, 0), 1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) do_read("R5 full read", a, 1'b0, 1'b0);

    // R6 / R3: lane-selective writes; every third address gets no lane
    for (int a = 0; a < DEPTH; a++) begin
      case (a % 3)
        0: do_write(a, pat(a, 1), 1'b0, 1'b1);
        1: do_write(a, pat(a, 1), 1'b1, 1'b0);
        default: do_write(a, pat(a, 1), 1'b1, 1'b1); // R3: no lane, model untouched
      endcase
    end
    for (int a = 0; a < DEPTH; a++) begin
      case (a % 3)
        0: do_read("R6 lower lane", a, 1'b0, 1'b1);
        1: do_read("R6 upper lane", a, 1'b1, 1'b0);
        default: do_read("R3 no-lane write kept data", a, 1'b0, 1'b0);
      endcase
    end

    // R3: selected, no lane, oe low: bus quiet
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4, 16'h0);
    settle();
    check("R3 no lane oe", {30'd0, dout_oe}, 32'd0);

    // R4: write with oe low; R7/R10: commit-cycle read and latency
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 16'hBEEF);
    settle();
    check("R4 write ignores oe", {30'd0, dout_oe}, 32'd0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5, 16'hBEEF);
    model[5] = 16'hBEEF;
    repeat (2) @(negedge clk);
    check("R10 not yet", {30'd0, dout_oe}, 32'd0);
    @(negedge clk);
    check("R10 on time", {30'd0, dout_oe}, 32'd3);
    check("R7 commit-cycle read", {16'd0, dout}, {16'd0, 16'hBEEF});

    // R5: selected read with oe high stays quiet
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5, 16'h0);
    settle();
    check("R5 oe high", {30'd0, dout_oe}, 32'd0);

    // R1 / R2: deselected by ce1_n and by ce2
    for (int v = 0; v < 2; v++) begin
      logic c1n, c2;
      c1n = (v == 0);
      c2  = (v == 0);
      drive(c1n, c2, 1'b0, 1'b0, 1'b0, 1'b0, 7, 16'h1234);
      settle();
      check("R1 standby write", {30'd0, dout_oe}, 32'd0);
      drive(c1n, c2, 1'b1, 1'b0, 1'b0, 1'b0, 7, 16'h1234);
      settle();
      check("R1 standby read", {30'd0, dout_oe}, 32'd0);
      check("R1 standby data", {16'd0, dout}, 32'd0);
      do_read("R2 contents untouched", 7, 1'b0, 1'b0);
    end

    // R7: write ended by deselect
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9, 16'hC0DE);
    settle();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9, 16'h0000);
    settle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9, 16'h0000);
    settle();
    model[9] = 16'hC0DE;
    do_read("R7 deselect commit", 9, 1'b0, 1'b0);

    // R8: page tracking
    do_read("R8 setup", 8, 1'b0, 1'b0);
    check("R8 held page", {31'd0, page_open}, 32'd1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9, 16'h0);
    repeat (3) @(negedge clk);
    check("R8 same page", {31'd0, page_open}, 32'd1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12, 16'h0);
    repeat (3) @(negedge clk);
    check("R8 new page", {31'd0, page_open}, 32'd0);
    @(negedge clk);
    check("R8 reopened", {31'd0, page_open}, 32'd1);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12, 16'h0);
    settle();
    check("R8 not reading", {31'd0, page_open}, 32'd0);

    // R9: reset during a read keeps contents
    do_read("R9 pre", 3, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset oe", {30'd0, dout_oe}, 32'd0);
    check("R9 reset page", {31'd0, page_open}, 32'd0);
    rst = 1'b0;
    settle();
    check("R9 contents kept oe", {30'd0, dout_oe}, 32'd3);
    check("R9 contents kept", {16'd0, dout}, {16'd0, model[3]});

    finish_run();
  end
endmodule